// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits next to a small microcontroller core and owns the power-control part of its status register. Five bits of that register set the operating state: a global interrupt enable, a core-off bit, an oscillator-off bit and two clock-generator-off bits. Every edge, the block works out the next register value. It decodes that value into a core halt signal, three clock enables (main, sub-main, auxiliary), a signal that stops the digitally controlled oscillator, and a 3-bit mode code. All of these come from registers that update on the same edge as the status register. This keeps the enables glitch-free, and the core stops in the cycle right after it sets the core-off bit.

An enabled interrupt wakes a halted core. When the block accepts an interrupt, it pushes the old status word onto a small internal stack. It then clears the enable and the four power bits in the live register, so the service routine runs with every clock on. A return strobe pops the saved word back. The core therefore drops back into the low-power mode it left, unless the service routine has cleared bits of the stacked word through the stack-clear port. The register file, memory and pins are not touched by mode changes. They simply stop being clocked.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While `rst` is high on a rising edge, the status word becomes 0, so `cpu_halt`=0, `mclk_en`=`smclk_en`=`aclk_en`=1, `dco_off`=0, `mode_code`=0 and `irq_ack`=0.
- R2: `mode_code` is 0 when core-off is 0. When core-off is 1, it is 5 if oscillator-off is 1, and otherwise it is 1 + {clkgen1-off, clkgen0-off} (values 1 to 4).
- R3: `mclk_en` is the inverse of core-off (bit 4), `smclk_en` is the inverse of clkgen1-off (bit 7), and `aclk_en` is the inverse of oscillator-off (bit 5).
- R4: `dco_off` is 1 exactly when clkgen0-off (bit 6), clkgen1-off and core-off are all 1.
- R5: A write through `sr_wr_en` is loaded on the next edge, and all outputs follow on that same edge. The bit positions are: interrupt enable bit 3, core-off bit 4, oscillator-off bit 5, clkgen0-off bit 6, clkgen1-off bit 7. Writing 0x18 gives `mode_code` 1 with `cpu_halt`=1.
- R6: While `cpu_halt` is 1, `sr_wr_en`, `reti` and `stk_bic_en` have no effect.
- R7: When `cpu_halt` is 1, bit 3 is set and any `irq_req & irq_en` bit is set, the next edge gives `mclk_en`=1 and `cpu_halt`=0, with a one-cycle `irq_ack` pulse.
- R8: A request whose `irq_en` bit is 0, or any request while bit 3 is 0, is not accepted. Only reset then ends the halt.
- R9: On acceptance, the old status word goes onto the stack (visible on `stk_top`). Bits 3 to 7 of the live word are cleared and all other bits are kept.
- R10: Outside a halt, `reti` with a non-empty stack loads the top entry into the status word and pops it. An unchanged entry puts the core back into its former mode.
- R11: Outside a halt, `stk_bic_en` clears the `stk_bic_mask` bits of the top stack entry. Clearing bit 4 makes the following `reti` resume with the core running.
- R12: If several enabled requests are present together, `irq_id` reports the lowest index.
- R13: While the stack holds `STK_DEPTH` entries, no request is accepted. A `reti` with an empty stack leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running source clock |
| rst | input | 1 | synchronous active-high reset |
| sr_wr_en | input | 1 | core writes the status word |
| sr_wr_data | input | SR_W | value written by the core |
| irq_req | input | N_IRQ | interrupt request lines |
| irq_en | input | N_IRQ | per-source interrupt enables |
| reti | input | 1 | return-from-interrupt strobe |
| stk_bic_en | input | 1 | clear bits of the top stack entry |
| stk_bic_mask | input | SR_W | bits to clear in the top entry |
| sr_q | output | SR_W | live status word |
| stk_top | output | SR_W | top stack entry (0 when empty) |
| cpu_halt | output | 1 | core stopped |
| mclk_en | output | 1 | main clock enable |
| smclk_en | output | 1 | sub-main clock enable |
| aclk_en | output | 1 | auxiliary clock enable |
| dco_off | output | 1 | stop the controlled oscillator |
| mode_code | output | 3 | current operating mode |
| irq_ack | output | 1 | one-cycle pulse on acceptance |
| irq_id | output | $clog2(N_IRQ) | index of the accepted source |

## Verification
The bench walks all six mode codes, plus the combinations where clock-generator bits are set while the core is still running. A decoder that treated them as sleep modes would wrongly drop `mclk_en` or raise `dco_off` there. It checks that a halted core ignores writes and returns, and that a request without its per-source enable or without bit 3 does not wake it. A design that got either wrong would leave sleep on a stray bus cycle. Wakeup is sampled exactly one edge after the request to catch a late enable, together with the stacked word and the cleared live word. The return paths are then followed both ways: an unmodified entry goes back to sleep, while an entry whose core-off bit was cleared resumes. The last cases fill the stack to its limit and pop it empty. A wrong full test would overwrite the oldest saved word, and a wrong empty test would load junk.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // status word bit positions decoded by this block
  localparam int BIT_IRQ_ON    = 3;
  localparam int BIT_CORE_OFF  = 4;
  localparam int BIT_OSC_OFF   = 5;
  localparam int BIT_GEN0_OFF  = 6;
  localparam int BIT_GEN1_OFF  = 7;

  typedef enum logic [2:0] {
    MODE_RUN  = 3'd0,
    MODE_LP0  = 3'd1,
    MODE_LP1  = 3'd2,
    MODE_LP2  = 3'd3,
    MODE_LP3  = 3'd4,
    MODE_LP4  = 3'd5
  } lpm_mode_e;

  typedef struct packed {
    logic      halt;
    logic      mclk;
    logic      smclk;
    logic      aclk;
    logic      dco_off;
    lpm_mode_e mode;
  } clk_state_t;

endpackage

// File: rtl/lpm_irq_arb.sv
module lpm_irq_arb #(
  parameter int N_IRQ = 8,
  parameter int IDW   = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] req,
  input  logic [N_IRQ-1:0] en,
  output logic             any,
  output logic [IDW-1:0]   id
);

  logic [N_IRQ-1:0] pend;
  logic [N_IRQ:0]   seen;
  logic [N_IRQ-1:0] grant;

  assign pend    = req & en;
  assign seen[0] = 1'b0;

  // lowest index wins: a grant needs no pending source below it
  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_chain
      assign seen[g+1] = seen[g] | pend[g];
      assign grant[g]  = pend[g] & ~seen[g];
    end
  endgenerate

  assign any = seen[N_IRQ];

  always_comb begin
    id = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (grant[i]) id = IDW'(i);
    end
  end

endmodule

// File: rtl/lpm_sr_stack.sv
module lpm_sr_stack #(
  parameter int SR_W  = 16,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [SR_W-1:0] push_data,
  input  logic            pop,
  input  logic            bic,
  input  logic [SR_W-1:0] bic_mask,
  output logic [SR_W-1:0] top,
  output logic [LW-1:0]   level,
  output logic            full,
  output logic            empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SR_W-1:0] mem [DEPTH];
  logic [LW-1:0]   top_lvl;
  logic [AW-1:0]   top_idx;
  logic [AW-1:0]   wr_idx;
  logic [SR_W-1:0] wr_data;
  logic            wr_en;

  assign top_lvl = level - LW'(1);
  assign top_idx = top_lvl[AW-1:0];
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign top     = empty ? '0 : mem[top_idx];

  // single write port: push writes the free slot, clear rewrites the top
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = top_idx;
    wr_data = '0;
    if (push && !full) begin
      wr_en   = 1'b1;
      wr_idx  = level[AW-1:0];
      wr_data = push_data;
    end else if (bic && !empty) begin
      wr_en   = 1'b1;
      wr_idx  = top_idx;
      wr_data = mem[top_idx] & ~bic_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (push && !full) begin
      level <= level + LW'(1);
    end else if (pop && !empty) begin
      level <= level - LW'(1);
    end
  end

endmodule

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
(
  input  logic       core_off,
  input  logic       osc_off,
  input  logic       gen0_off,
  input  logic       gen1_off,
  output clk_state_t st
);

  always_comb begin
    st.halt    = core_off;
    st.mclk    = ~core_off;
    st.smclk   = ~gen1_off;
    st.aclk    = ~osc_off;
    st.dco_off = gen0_off & gen1_off & core_off;
    if (!core_off) begin
      st.mode = MODE_RUN;
    end else if (osc_off) begin
      st.mode = MODE_LP4;
    end else begin
      unique case ({gen1_off, gen0_off})
        2'b00:   st.mode = MODE_LP0;
        2'b01:   st.mode = MODE_LP1;
        2'b10:   st.mode = MODE_LP2;
        default: st.mode = MODE_LP3;
      endcase
    end
  end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int N_IRQ     = 8,
  parameter int STK_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sr_wr_en,
  input  logic [SR_W-1:0]          sr_wr_data,
  input  logic [N_IRQ-1:0]         irq_req,
  input  logic [N_IRQ-1:0]         irq_en,
  input  logic                     reti,
  input  logic                     stk_bic_en,
  input  logic [SR_W-1:0]          stk_bic_mask,
  output logic [SR_W-1:0]          sr_q,
  output logic [SR_W-1:0]          stk_top,
  output logic                     cpu_halt,
  output logic                     mclk_en,
  output logic                     smclk_en,
  output logic                     aclk_en,
  output logic                     dco_off,
  output logic [2:0]               mode_code,
  output logic                     irq_ack,
  output logic [$clog2(N_IRQ)-1:0] irq_id
);

  localparam int IDW = $clog2(N_IRQ);
  localparam int LW  = $clog2(STK_DEPTH + 1);

  // bits cleared on acceptance: enable plus the four power bits
  localparam logic [SR_W-1:0] CLR_MASK =
      (SR_W'(1) << BIT_IRQ_ON)   | (SR_W'(1) << BIT_CORE_OFF) |
      (SR_W'(1) << BIT_OSC_OFF)  | (SR_W'(1) << BIT_GEN0_OFF) |
      (SR_W'(1) << BIT_GEN1_OFF);

  logic             pend_any;
  logic [IDW-1:0]   pend_id;
  logic             stk_full;
  logic             stk_empty;
  logic [LW-1:0]    stk_level;
  logic             accept;
  logic             do_reti;
  logic             do_bic;
  logic             do_wr;
  logic [SR_W-1:0]  sr_nxt;
  clk_state_t       st_nxt;

  lpm_irq_arb #(
    .N_IRQ (N_IRQ),
    .IDW   (IDW)
  ) i_arb (
    .req (irq_req),
    .en  (irq_en),
    .any (pend_any),
    .id  (pend_id)
  );

  // control decisions; a halted core issues no bus cycle
  assign accept  = sr_q[BIT_IRQ_ON] & pend_any & ~stk_full;
  assign do_reti = reti & ~cpu_halt & ~stk_empty & ~accept;
  assign do_bic  = stk_bic_en & ~cpu_halt & ~accept & ~do_reti;
  assign do_wr   = sr_wr_en & ~cpu_halt & ~accept & ~do_reti;

  lpm_sr_stack #(
    .SR_W  (SR_W),
    .DEPTH (STK_DEPTH),
    .LW    (LW)
  ) i_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (accept),
    .push_data (sr_q),
    .pop       (do_reti),
    .bic       (do_bic),
    .bic_mask  (stk_bic_mask),
    .top       (stk_top),
    .level     (stk_level),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  always_comb begin
    sr_nxt = sr_q;
    if (accept)       sr_nxt = sr_q & ~CLR_MASK;
    else if (do_reti) sr_nxt = stk_top;
    else if (do_wr)   sr_nxt = sr_wr_data;
  end

  lpm_mode_decode i_dec (
    .core_off (sr_nxt[BIT_CORE_OFF]),
    .osc_off  (sr_nxt[BIT_OSC_OFF]),
    .gen0_off (sr_nxt[BIT_GEN0_OFF]),
    .gen1_off (sr_nxt[BIT_GEN1_OFF]),
    .st       (st_nxt)
  );

  // status word and every output move on the same source-clock edge
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= '0;
      cpu_halt  <= 1'b0;
      mclk_en   <= 1'b1;
      smclk_en  <= 1'b1;
      aclk_en   <= 1'b1;
      dco_off   <= 1'b0;
      mode_code <= MODE_RUN;
      irq_ack   <= 1'b0;
      irq_id    <= '0;
    end else begin
      sr_q      <= sr_nxt;
      cpu_halt  <= st_nxt.halt;
      mclk_en   <= st_nxt.mclk;
      smclk_en  <= st_nxt.smclk;
      aclk_en   <= st_nxt.aclk;
      dco_off   <= st_nxt.dco_off;
      mode_code <= st_nxt.mode;
      irq_ack   <= accept;
      if (accept) irq_id <= pend_id;
    end
  end

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int N_IRQ     = 8,
  parameter int STK_DEPTH = 4,
  parameter int LW        = $clog2(STK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [SR_W-1:0]  sr_q,
  input logic             cpu_halt,
  input logic             mclk_en,
  input logic             irq_ack,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             stk_full,
  input logic [LW-1:0]    stk_level
);

  AST_WAKE_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && sr_q[BIT_IRQ_ON] && |(irq_req & irq_en) && !stk_full)
      |=> (mclk_en && !cpu_halt)); // R7

  AST_HALT_FREEZES_SR: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !(sr_q[BIT_IRQ_ON] && |(irq_req & irq_en)))
      |=> $stable(sr_q)); // R6

  AST_ACK_CLEARS_PWR: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (sr_q[BIT_GEN1_OFF:BIT_IRQ_ON] == '0 && !cpu_halt)); // R9

  AST_NO_ACK_MASKED: assert property (@(posedge clk) disable iff (rst)
    !$past(sr_q[BIT_IRQ_ON]) |-> !irq_ack); // R8

  AST_MCLK_TRACKS_CORE_OFF: assert property (@(posedge clk) disable iff (rst)
    !$stable(mclk_en) |-> !$stable(sr_q[BIT_CORE_OFF])); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(stk_level) <= STK_DEPTH); // R13

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(
  .SR_W      (SR_W),
  .N_IRQ     (N_IRQ),
  .STK_DEPTH (STK_DEPTH)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .sr_q      (sr_q),
  .cpu_halt  (cpu_halt),
  .mclk_en   (mclk_en),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .irq_en    (irq_en),
  .stk_full  (stk_full),
  .stk_level (stk_level)
);

// File: tb/test_lpm_clk_ctrl.sv
module test_lpm_clk_ctrl;

  localparam int CLK_P     = 10;
  localparam int SR_W      = 16;
  localparam int N_IRQ     = 8;
  localparam int STK_DEPTH = 4;
  localparam int WD_LIMIT  = 20000;

  // {status byte, halt, mclk, smclk, aclk, dco_off, mode}
  localparam logic [15:0] VEC [9] = '{
    {8'h00, 5'b01110, 3'd0},
    {8'h18, 5'b10110, 3'd1},
    {8'h50, 5'b10110, 3'd2},
    {8'h90, 5'b10010, 3'd3},
    {8'hD0, 5'b10011, 3'd4},
    {8'hF0, 5'b10001, 3'd5},
    {8'h30, 5'b10100, 3'd5},
    {8'hC0, 5'b01010, 3'd0},
    {8'h20, 5'b01100, 3'd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sr_wr_en = 1'b0;
  logic [SR_W-1:0]  sr_wr_data = '0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic [N_IRQ-1:0] irq_en = '0;
  logic             reti = 1'b0;
  logic             stk_bic_en = 1'b0;
  logic [SR_W-1:0]  stk_bic_mask = '0;
  logic [SR_W-1:0]  sr_q;
  logic [SR_W-1:0]  stk_top;
  logic             cpu_halt, mclk_en, smclk_en, aclk_en, dco_off, irq_ack;
  logic [2:0]       mode_code;
  logic [2:0]       irq_id;
  logic [7:0]       outs;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  lpm_clk_ctrl #(
    .SR_W      (SR_W),
    .N_IRQ     (N_IRQ),
    .STK_DEPTH (STK_DEPTH)
  ) i_lpm_clk_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sr_wr_en     (sr_wr_en),
    .sr_wr_data   (sr_wr_data),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .reti         (reti),
    .stk_bic_en   (stk_bic_en),
    .stk_bic_mask (stk_bic_mask),
    .sr_q         (sr_q),
    .stk_top      (stk_top),
    .cpu_halt     (cpu_halt),
    .mclk_en      (mclk_en),
    .smclk_en     (smclk_en),
    .aclk_en      (aclk_en),
    .dco_off      (dco_off),
    .mode_code    (mode_code),
    .irq_ack      (irq_ack),
    .irq_id       (irq_id)
  );

  assign outs = {cpu_halt, mclk_en, smclk_en, aclk_en, dco_off, mode_code};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [SR_W-1:0] v);
    sr_wr_en   = 1'b1;
    sr_wr_data = v;
    step();
    sr_wr_en   = 1'b0;
  endtask

  task automatic irq_pulse(input logic [N_IRQ-1:0] r);
    irq_req = r;
    step();
    irq_req = '0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step();
    reti = 1'b0;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", WD_LIMIT);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    check(outs == 8'b01110_000 && sr_q == '0 && !irq_ack, "R1",
          {8'h0, sr_q, outs}, 32'h0000_0070);

    // R2 R3 R4 R5 decode table
    for (int k = 0; k < 9; k++) begin
      do_reset();
      wr({8'h00, VEC[k][15:8]});
      check(outs == VEC[k][7:0], "R2 R3 R4", outs, VEC[k][7:0]);
      check(sr_q == {8'h00, VEC[k][15:8]}, "R5", sr_q, {8'h00, VEC[k][15:8]});
    end

    // R6 writes, returns and stack clears ignored while halted
    do_reset();
    wr(16'h0018);
    wr(16'h0000);
    reti = 1'b1; stk_bic_en = 1'b1; stk_bic_mask = 16'hFFFF;
    step();
    reti = 1'b0; stk_bic_en = 1'b0;
    check(sr_q == 16'h0018 && cpu_halt, "R6", sr_q, 16'h0018);

    // R8 request without its enable
    irq_en = 8'h02;
    irq_pulse(8'h01);
    check(cpu_halt && !irq_ack, "R8", {cpu_halt, irq_ack}, 2'b10);
    // R8 enabled request but interrupt enable bit clear
    do_reset();
    wr(16'h0010);
    irq_en = 8'h01;
    irq_pulse(8'h01);
    check(cpu_halt && sr_q == 16'h0010, "R8", sr_q, 16'h0010);

    // R7 R9 wake from mode 4 equivalent (0xD8)
    do_reset();
    wr(16'h00D8);
    irq_en = 8'h04;
    irq_pulse(8'h04);
    check(mclk_en && !cpu_halt && irq_ack && irq_id == 3'd2, "R7",
          {mclk_en, cpu_halt, irq_ack, irq_id}, {3'b101, 3'd2});
    check(sr_q == 16'h0000 && outs == 8'b01110_000, "R9", sr_q, 16'h0000);
    check(stk_top == 16'h00D8, "R9", stk_top, 16'h00D8);
    step();
    check(!irq_ack, "R7", irq_ack, 1'b0);

    // R10 return without changes goes back to sleep
    do_reti();
    check(sr_q == 16'h00D8 && cpu_halt && mode_code == 3'd4 && !smclk_en, "R10",
          {sr_q, outs}, {16'h00D8, 8'b10011_100});

    // R11 clear stacked core-off bit, then return resumes running
    irq_pulse(8'h04);
    stk_bic_en = 1'b1; stk_bic_mask = 16'h0010;
    step();
    stk_bic_en = 1'b0;
    check(stk_top == 16'h00C8, "R11", stk_top, 16'h00C8);
    do_reti();
    check(sr_q == 16'h00C8 && outs == 8'b01010_000, "R11",
          {sr_q, outs}, {16'h00C8, 8'b01010_000});

    // R12 lowest index wins
    irq_en = 8'hFF;
    irq_pulse(8'h0A);
    check(irq_ack && irq_id == 3'd1, "R12", irq_id, 3'd1);

    // R13 full stack blocks acceptance, then pop in order
    do_reset();
    irq_en = 8'hFF;
    wr(16'h0018);
    irq_pulse(8'h80);
    for (int j = 0; j < STK_DEPTH - 1; j++) begin
      wr(16'h0008);
      irq_pulse(8'h80);
    end
    wr(16'h0008);
    irq_pulse(8'h80);
    check(!irq_ack && sr_q == 16'h0008, "R13", sr_q, 16'h0008);
    for (int j = 0; j < STK_DEPTH - 1; j++) begin
      do_reti();
      check(sr_q == 16'h0008 && !cpu_halt, "R10", sr_q, 16'h0008);
    end
    do_reti();
    check(sr_q == 16'h0018 && cpu_halt, "R10", sr_q, 16'h0018);

    // R13 return with empty stack
    do_reset();
    wr(16'h0008);
    do_reti();
    check(sr_q == 16'h0008 && !cpu_halt, "R13", sr_q, 16'h0008);

    summary();
    $finish;
  end

endmodule